// File: doc/BRIEF.md
# Clear-on-Read Peak Level Monitor

This block watches the sample stream from three converter channels, left, right and mono, and keeps a separate peak record for each. Each sample arrives with a valid strobe and a channel tag. The block takes its magnitude and compares it with the stored peak for that channel. The stored value only ever rises, until software reads it.

A read names one channel. It returns that channel's stored peak one clock later, and in the same step it zeroes the record so that tracking starts again. Each channel has its own mute bit. A muted channel's samples enter the monitor as zero, so its record cannot rise while the mute is set. A sample that lands in the same cycle as a read of its own channel is kept: the read returns the old peak and the sample's magnitude becomes the new record.

Top module: `peak_level_monitor`

## Requirements
- R1: After reset, every channel's stored peak is 0 and `rd_data` is 0. A reset applied in mid-run discards all stored peaks.
- R2: The magnitude of a 16-bit two's-complement sample is its absolute value. The value -32768 (0x8000) saturates to 32767.
- R3: A channel's stored peak is the largest magnitude among the valid samples accepted since that channel was last read. A smaller sample leaves it unchanged.
- R4: The channel tag encodes left as 0, right as 1 and mono as 2. A sample tagged 3 updates no channel, and a sample updates only the channel its tag names.
- R5: A read with `rd_en` high and channel `rd_chan` places that channel's stored peak on `rd_data` on the next clock. `rd_data` holds that value until the next read. Reading channel 3 returns 0.
- R6: A read sets the stored peak of the channel it names to 0. The other channels are not affected.
- R7: When a valid sample for the channel being read arrives in the same cycle as the read, the read returns the old peak and the sample's magnitude becomes the new stored peak.
- R8: The mute bits are bit 0 for left, bit 1 for right and bit 2 for mono. A valid sample on a muted channel counts as magnitude 0.
- R9: While `smp_valid` is low, the sample inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 2 | Sample channel tag (0 left, 1 right, 2 mono) |
| smp_data | input | 16 | Signed sample |
| mute | input | 3 | Per-channel mute, bit 0 left, bit 1 right, bit 2 mono |
| rd_en | input | 1 | Read-and-clear strobe |
| rd_chan | input | 2 | Channel to read |
| rd_data | output | 15 | Registered peak from the last read |

## Verification
Two events can fall in the same cycle: the clear performed by a read, and a peak update caused by an incoming sample. The bench raises a read strobe and a valid sample on the same edge. It does this once for the channel being read and once for a different channel. It then checks that the returned value is the peak from before that edge, and that a second read returns exactly the colliding sample's magnitude. In the cross-channel case it checks that the other channel keeps its update.

// File: rtl/plm_pkg.sv
// Shared constants and types for the peak level monitor.
// Assumes exactly three monitored channels and a 2-bit channel tag.
package plm_pkg;
    localparam int NCH    = 3;
    localparam int CHAN_W = 2;

    typedef enum logic [CHAN_W-1:0] {
        CH_LEFT  = 2'd0,
        CH_RIGHT = 2'd1,
        CH_MONO  = 2'd2,
        CH_NONE  = 2'd3
    } chan_e;
endpackage

// File: rtl/plm_magnitude.sv
// Absolute value of a signed sample, with the most negative code
// saturated to the largest positive magnitude.
// Assumes two's-complement input; purely combinational.
module plm_magnitude #(
    parameter int DATA_W = 16,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [MAG_W-1:0]  mag_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [MAG_W-1:0]  MAG_MAX  = {MAG_W{1'b1}};

    logic [DATA_W-1:0] negated;

    // Form the two's-complement negation and pick the magnitude.
    always_comb begin
        negated = ~data_i + 1'b1;
        if (data_i == MOST_NEG)
            mag_o = MAG_MAX;
        else if (data_i[DATA_W-1])
            mag_o = negated[MAG_W-1:0];
        else
            mag_o = data_i[MAG_W-1:0];
    end
endmodule

// File: rtl/plm_peak_cell.sv
// One channel's peak register. Rises on larger hits. A clear loads the
// colliding hit's magnitude, or zero when there is no hit.
// Assumes mag_i is already mute-gated and hit_i already decoded.
module plm_peak_cell #(
    parameter int MAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             clr_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0] peak_o
);
    // Hold the running maximum, restarting on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            peak_o <= '0;
        else if (clr_i)
            peak_o <= hit_i ? mag_i : '0;
        else if (hit_i && (mag_i > peak_o))
            peak_o <= mag_i;
    end
endmodule

// File: rtl/peak_level_monitor.sv
// Clear-on-read peak monitor for three converter channels.
// Decodes sample tags, gates muted channels to zero, keeps one peak
// cell per channel and returns a registered read that also clears.
// Assumes single-cycle read strobes; tag 3 addresses no channel.
module peak_level_monitor
    import plm_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [NCH-1:0]    mute,
    input  logic              rd_en,
    input  logic [CHAN_W-1:0] rd_chan,
    output logic [MAG_W-1:0]  rd_data
);
    logic [MAG_W-1:0]            mag_raw;
    logic [NCH-1:0][MAG_W-1:0]   peak_q;
    logic [MAG_W-1:0]            rd_sel;

    plm_magnitude #(.DATA_W(DATA_W)) u_mag (
        .data_i (smp_data),
        .mag_o  (mag_raw)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             hit;
        logic             clr;
        logic [MAG_W-1:0] mag_gated;

        // Decode this channel's hit, clear and mute-gated magnitude.
        always_comb begin
            hit       = smp_valid && (smp_chan == CHAN_W'(c));
            clr       = rd_en && (rd_chan == CHAN_W'(c));
            mag_gated = mute[c] ? '0 : mag_raw;
        end

        plm_peak_cell #(.MAG_W(MAG_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hit),
            .clr_i  (clr),
            .mag_i  (mag_gated),
            .peak_o (peak_q[c])
        );
    end

    // Select the addressed channel's peak, or zero for an unused tag.
    always_comb begin
        rd_sel = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_chan == CHAN_W'(c))
                rd_sel = peak_q[c];
    end

    // Register the read result and hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_sel;
    end
endmodule

// File: rtl/plm_checker.sv
// Temporal checks for peak_level_monitor, attached with bind.
// Assumes the top exposes its packed per-channel peak array peak_q.
module plm_checker
    import plm_pkg::*;
#(
    parameter int MAG_W = 15
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      smp_valid,
    input logic [CHAN_W-1:0]         smp_chan,
    input logic [NCH-1:0]            mute,
    input logic                      rd_en,
    input logic [CHAN_W-1:0]         rd_chan,
    input logic [MAG_W-1:0]          rd_data,
    input logic [NCH-1:0][MAG_W-1:0] peak_q
);
    logic [MAG_W-1:0] exp_sel;

    // Peak the next read must return, derived from the addressed channel.
    always_comb begin
        exp_sel = '0;
        if (rd_chan == CHAN_W'(CH_LEFT))  exp_sel = peak_q[0];
        if (rd_chan == CHAN_W'(CH_RIGHT)) exp_sel = peak_q[1];
        if (rd_chan == CHAN_W'(CH_MONO))  exp_sel = peak_q[2];
    end

    // R5: the read result appears one clock after the strobe.
    a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data == $past(exp_sel));

    // R5: the read result holds between reads.
    a_r5_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: without a read of this channel its peak never falls.
        a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_en && rd_chan == CHAN_W'(c)) |=> peak_q[c] >= $past(peak_q[c]));

        // R6: a read with no colliding sample leaves the channel at zero.
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_chan == CHAN_W'(c) && !(smp_valid && smp_chan == CHAN_W'(c)))
            |=> peak_q[c] == '0);

        // R8: a muted sample cannot raise the record.
        a_r8_mute_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_chan == CHAN_W'(c) && mute[c] && !(rd_en && rd_chan == CHAN_W'(c)))
            |=> $stable(peak_q[c]));

        // R4, R9: with no hit and no read for this channel the record is stable.
        a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(smp_valid && smp_chan == CHAN_W'(c)) && !(rd_en && rd_chan == CHAN_W'(c)))
            |=> $stable(peak_q[c]));
    end
endmodule

bind peak_level_monitor plm_checker #(.MAG_W(MAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .mute      (mute),
    .rd_en     (rd_en),
    .rd_chan   (rd_chan),
    .rd_data   (rd_data),
    .peak_q    (peak_q)
);

// File: tb/sim_peak_level_monitor.sv
`timescale 1ns/1ps
module sim_peak_level_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_chan = 2'd0;
    logic [15:0] smp_data = 16'd0;
    logic [2:0]  mute = 3'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_chan = 2'd0;
    logic [14:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    peak_level_monitor u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .mute(mute), .rd_en(rd_en), .rd_chan(rd_chan),
        .rd_data(rd_data)
    );

    // Vector: {is_read, chan, mute, data, expected read}
    localparam int NV = 22;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'b000, 16'd100,   15'd0},
        {1'b0, 2'd0, 3'b000, 16'hFED4,  15'd0},
        {1'b0, 2'd0, 3'b000, 16'd200,   15'd0},
        {1'b1, 2'd0, 3'b000, 16'd0,     15'd300},
        {1'b1, 2'd0, 3'b000, 16'd0,     15'd0},
        {1'b0, 2'd1, 3'b000, 16'h8000,  15'd0},
        {1'b0, 2'd2, 3'b000, 16'h7FFF,  15'd0},
        {1'b0, 2'd2, 3'b000, 16'hFFFF,  15'd0},
        {1'b1, 2'd1, 3'b000, 16'd0,     15'd32767},
        {1'b1, 2'd2, 3'b000, 16'd0,     15'd32767},
        {1'b0, 2'd0, 3'b001, 16'd50,    15'd0},
        {1'b0, 2'd0, 3'b000, 16'd60,    15'd0},
        {1'b0, 2'd1, 3'b010, 16'd70,    15'd0},
        {1'b1, 2'd0, 3'b000, 16'd0,     15'd60},
        {1'b1, 2'd1, 3'b000, 16'd0,     15'd0},
        {1'b0, 2'd3, 3'b000, 16'd12345, 15'd0},
        {1'b1, 2'd0, 3'b000, 16'd0,     15'd0},
        {1'b1, 2'd1, 3'b000, 16'd0,     15'd0},
        {1'b1, 2'd2, 3'b000, 16'd0,     15'd0},
        {1'b0, 2'd0, 3'b000, 16'd5,     15'd0},
        {1'b1, 2'd3, 3'b000, 16'd0,     15'd0},
        {1'b1, 2'd0, 3'b000, 16'd0,     15'd5}
    };
    localparam string VTAG [NV] = '{
        "", "", "", "R2/R3", "R6", "", "", "", "R2", "R3", "", "", "",
        "R8", "R8", "", "R4", "R4", "R6", "", "R5", "R4"
    };

    task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs from a negedge, then return at the next negedge.
    task automatic step(input logic sv, input logic [1:0] sc, input logic [15:0] sd,
                        input logic [2:0] m, input logic re, input logic [1:0] rc);
        smp_valid = sv; smp_chan = sc; smp_data = sd; mute = m;
        rd_en = re; rd_chan = rc;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0; rd_en = 1'b0; mute = 3'b000;
    endtask

    task automatic rd_check(input logic [1:0] ch, input logic [14:0] exp, input string tag);
        step(1'b0, 2'd0, 16'd0, 3'b000, 1'b1, ch);
        check(tag, rd_data, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: rd_data=%0d expected=completion", rd_data);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", rd_data, 15'd0);
        for (int c = 0; c < 3; c++) rd_check(2'(c), 15'd0, "R1 reset peak");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) begin
                rd_check(VEC[i][35:34], VEC[i][14:0], VTAG[i]);
            end else begin
                step(1'b1, VEC[i][35:34], VEC[i][30:15], VEC[i][33:31], 1'b0, 2'd0);
            end
        end

        // R7: same-channel collision keeps the new sample.
        step(1'b1, 2'd0, 16'd400, 3'b000, 1'b0, 2'd0);
        step(1'b1, 2'd0, 16'd150, 3'b000, 1'b1, 2'd0);
        check("R7 old peak returned", rd_data, 15'd400);
        rd_check(2'd0, 15'd150, "R7 colliding sample kept");
        rd_check(2'd0, 15'd0, "R7 cleared after");

        // R6: a read of one channel while another channel samples.
        step(1'b1, 2'd2, 16'd20, 3'b000, 1'b0, 2'd0);
        step(1'b1, 2'd0, 16'hFC7C, 3'b000, 1'b1, 2'd2);
        check("R6 cross read", rd_data, 15'd20);
        rd_check(2'd0, 15'd900, "R6 other channel kept");
        rd_check(2'd2, 15'd0, "R6 read channel cleared");

        // R9: inputs without the strobe are ignored.
        step(1'b0, 2'd1, 16'd7000, 3'b000, 1'b0, 2'd0);
        rd_check(2'd1, 15'd0, "R9 no strobe");

        // R5: the read result holds over idle cycles.
        step(1'b1, 2'd1, 16'd33, 3'b000, 1'b0, 2'd0);
        rd_check(2'd1, 15'd33, "R5 read");
        step(1'b1, 2'd1, 16'd44, 3'b000, 1'b0, 2'd0);
        step(1'b0, 2'd0, 16'd0, 3'b000, 1'b0, 2'd0);
        check("R5 hold", rd_data, 15'd33);

        // R1: reset in mid-run discards the stored peak.
        step(1'b1, 2'd1, 16'd1000, 3'b000, 1'b0, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run reset output", rd_data, 15'd0);
        rd_check(2'd1, 15'd0, "R1 mid-run reset peak");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule